// File: doc/BRIEF.md
# DMA Destination Address Generator

This block is the destination-side address unit of one DMA channel. Software programs a start address, a control word and a unit count through a small register port. When the channel is acknowledged it begins accepting transfer beats. After each beat the current destination pointer either moves forward by the beat's data size or stays where it is. In fixed-address mode a four-beat burst still walks through consecutive addresses, and the pointer then returns to the burst's first address.

The block counts completed units. A unit is one beat in single mode and one full burst in burst mode. At terminal count the channel either stops, or, with auto-reload enabled, spends one cycle reloading the count and the start address and then continues. A one-cycle interrupt pulse marks either the terminal count or the completed reload, as selected by software. A control bit chooses whether the destination sits on the system bus or the peripheral bus, and that choice is driven out as a plain flag.

Beats follow valid/ready rules. A beat is taken on a rising edge where `beat_valid` and `beat_ready` are both high, and `beat_size` and `burst_mode` are sampled on that same edge. `beat_valid` may stay high while `beat_ready` is low, and nothing happens until ready returns. `beat_ready` is high only while the channel is running and not reloading.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After reset, every register reads zero, and `dst_addr`, `irq`, `beat_ready` and `dst_periph` are all low.
- R2: Register map on `reg_addr`: 0 is the start address (31 bits), 1 is control (bit0 fixed, bit1 peripheral, bit2 interrupt-after-reload, bit3 auto-reload enable), 2 is the unit count (8 bits), 3 is the current pointer (writable). A write takes effect on the next edge. Reads are combinational. Unimplemented bits read zero.
- R3: `dma_ack` while idle starts the channel (`beat_ready` is high on the next cycle) and loads the unit count. The start address is copied into the pointer only if the pointer is zero at that edge. Otherwise the pointer keeps its value.
- R4: In increment mode (bit0=0), each accepted beat adds 1, 2 or 4 to the pointer for `beat_size` 00, 01 or 10. The code 11 also adds 4.
- R5: In fixed mode with `burst_mode`=0, an accepted beat leaves the pointer unchanged.
- R6: In fixed mode with `burst_mode`=1, beats 1 to 3 of a four-beat burst each step the pointer by the size. The fourth beat returns it to the value it had before the first beat. In increment mode all four beats step.
- R7: After the programmed number of units without auto-reload, `beat_ready` is low from the next cycle on, and `irq` is high for exactly that one cycle.
- R8: With auto-reload, the cycle after the terminal beat has `beat_ready` low. On the cycle after that, the pointer equals the start address, the count is reloaded and `beat_ready` is high again.
- R9: With auto-reload and bit2=0, `irq` pulses in the cycle after the terminal beat. With bit2=1 it pulses one cycle later, together with the reloaded pointer. The pulse is always one cycle long.
- R10: `dst_periph` follows control bit1.
- R11: `dma_ack` while running is ignored. `beat_valid` while `beat_ready` is low does not move the pointer.
- R12: A write to the start address in the same cycle as the terminal beat is the value used by the reload that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_ack | input | 1 | Channel acknowledge, starts an idle channel |
| beat_valid | input | 1 | A transfer beat is offered |
| beat_ready | output | 1 | Channel can accept a beat |
| beat_size | input | 2 | Beat data size: 00 byte, 01 halfword, 10/11 word |
| burst_mode | input | 1 | 1 = four-beat bursts, 0 = single beats |
| dst_addr | output | 31 | Current destination pointer |
| dst_periph | output | 1 | 1 = destination on peripheral bus |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The terminal beat of a reload-enabled channel and a software write to the start address can fall on the same edge. The reload then has to pick up the new address and not the stale one. The bench provokes this by raising `reg_wr` to the start-address register together with the last `beat_valid` of the run. It judges the result by the pointer two cycles later, which must equal the newly written address. An `dma_ack` held high during the first beat of every sweep case also checks that a start request overlapping a running transfer changes neither the count nor the pointer.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_RELOAD = 2'd2
  } chan_st_e;

  // control word, bit 3 down to bit 0
  typedef struct packed {
    logic reload_en;
    logic irq_after_reload;
    logic periph;
    logic fixed;
  } dst_ctrl_t;

  localparam logic [1:0] RA_INIT  = 2'd0;
  localparam logic [1:0] RA_CTRL  = 2'd1;
  localparam logic [1:0] RA_COUNT = 2'd2;
  localparam logic [1:0] RA_PTR   = 2'd3;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'b00:   size_step = 3'd1;
      2'b01:   size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_dst_regs.sv
module dma_dst_regs
  import dma_dst_pkg::*;
#(
  parameter int ADDR_W  = 31,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [ADDR_W-1:0]  ptr_q,
  output logic [ADDR_W-1:0]  init_q,
  output dst_ctrl_t          ctrl_q,
  output logic [COUNT_W-1:0] count_q,
  output logic               ptr_wr,
  output logic [31:0]        reg_rdata
);

  localparam int CTRL_W = $bits(dst_ctrl_t);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= '0;
      ctrl_q  <= '0;
      count_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_INIT:  init_q  <= reg_wdata[ADDR_W-1:0];
        RA_CTRL:  ctrl_q  <= dst_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RA_COUNT: count_q <= reg_wdata[COUNT_W-1:0];
        default:  ;
      endcase
    end
  end

  assign ptr_wr = reg_wr && (reg_addr == RA_PTR);

  always_comb begin
    case (reg_addr)
      RA_INIT:  reg_rdata = 32'(init_q);
      RA_CTRL:  reg_rdata = 32'(ctrl_q);
      RA_COUNT: reg_rdata = 32'(count_q);
      default:  reg_rdata = 32'(ptr_q);
    endcase
  end

  assert_ctrl_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_CTRL) |=> (ctrl_q == $past(reg_wdata[CTRL_W-1:0])));

endmodule

// File: rtl/dma_dst_seq.sv
module dma_dst_seq
  import dma_dst_pkg::*;
#(
  parameter int COUNT_W   = 8,
  parameter int BURST_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_ack,
  input  logic               beat_valid,
  input  logic               burst_mode,
  input  dst_ctrl_t          ctrl_q,
  input  logic [COUNT_W-1:0] count_q,
  output logic               beat_ready,
  output logic               fire,
  output logic               first_beat,
  output logic               last_beat,
  output logic               start,
  output logic               reload_now,
  output logic               irq
);

  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  chan_st_e           state;
  logic [COUNT_W-1:0] cnt;
  logic [BEAT_W-1:0]  idx;
  logic               pend;
  logic               unit_done, terminal;

  assign beat_ready = (state == ST_RUN);
  assign fire       = beat_valid && beat_ready;
  assign first_beat = (idx == '0);
  assign last_beat  = !burst_mode || (idx == BEAT_W'(BURST_LEN - 1));
  assign start      = (state == ST_IDLE) && dma_ack;
  assign reload_now = (state == ST_RELOAD);
  assign unit_done  = fire && last_beat;
  assign terminal   = unit_done && (cnt == COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      pend  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (dma_ack) begin
            state <= ST_RUN;
            cnt   <= count_q;
            idx   <= '0;
          end
        end
        ST_RUN: begin
          if (fire) idx <= last_beat ? '0 : idx + BEAT_W'(1);
          if (unit_done) cnt <= cnt - COUNT_W'(1);
          if (terminal) begin
            state <= ctrl_q.reload_en ? ST_RELOAD : ST_IDLE;
            irq   <= !ctrl_q.reload_en || !ctrl_q.irq_after_reload;
            pend  <= ctrl_q.reload_en && ctrl_q.irq_after_reload;
          end
        end
        ST_RELOAD: begin
          state <= ST_RUN;
          cnt   <= count_q;
          idx   <= '0;
          irq   <= pend;
          pend  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_beat && cnt == COUNT_W'(1) && !ctrl_q.reload_en) |=> (!beat_ready && irq));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELOAD) |=> (beat_ready && cnt == $past(count_q)));

  assert_ack_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && dma_ack && !fire) |=> $stable(cnt));

endmodule

// File: rtl/dma_dst_ptr.sv
module dma_dst_ptr
  import dma_dst_pkg::*;
#(
  parameter int ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              first_beat,
  input  logic              last_beat,
  input  logic              burst_mode,
  input  logic [1:0]        beat_size,
  input  logic              fixed,
  input  logic              start,
  input  logic              reload_now,
  input  logic [ADDR_W-1:0] init_q,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_data,
  output logic [ADDR_W-1:0] ptr_q
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] step;

  assign step = ADDR_W'(size_step(beat_size));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (reload_now) begin
      ptr_q <= init_q;
    end else if (sw_wr) begin
      ptr_q <= sw_data;
    end else if (start && ptr_q == '0) begin
      ptr_q <= init_q;
    end else if (fire) begin
      if (burst_mode) begin
        if (first_beat) base_q <= ptr_q;
        if (last_beat && fixed) ptr_q <= first_beat ? ptr_q : base_q;
        else                    ptr_q <= ptr_q + step;
      end else if (!fixed) begin
        ptr_q <= ptr_q + step;
      end
    end
  end

  assert_fixed_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !burst_mode && fixed && !sw_wr && !reload_now) |=> $stable(ptr_q));

  assert_inc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !fixed && !sw_wr && !reload_now) |=> (ptr_q == $past(ptr_q) + $past(step)));

  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ptr_q == '0 && !sw_wr && !reload_now) |=> (ptr_q == $past(init_q)));

  assert_burst_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && burst_mode && fixed && last_beat && !first_beat && !sw_wr && !reload_now)
      |=> (ptr_q == $past(base_q)));

endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen
  import dma_dst_pkg::*;
#(
  parameter int ADDR_W    = 31,
  parameter int COUNT_W   = 8,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dma_ack,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [1:0]        beat_size,
  input  logic              burst_mode,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_periph,
  output logic              irq
);

  logic [ADDR_W-1:0]  init_q, ptr_q;
  dst_ctrl_t          ctrl_q;
  logic [COUNT_W-1:0] count_q;
  logic               ptr_wr, fire, first_beat, last_beat, start, reload_now;

  dma_dst_regs #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ptr_q     (ptr_q),
    .init_q    (init_q),
    .ctrl_q    (ctrl_q),
    .count_q   (count_q),
    .ptr_wr    (ptr_wr),
    .reg_rdata (reg_rdata)
  );

  dma_dst_seq #(.COUNT_W(COUNT_W), .BURST_LEN(BURST_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_ack    (dma_ack),
    .beat_valid (beat_valid),
    .burst_mode (burst_mode),
    .ctrl_q     (ctrl_q),
    .count_q    (count_q),
    .beat_ready (beat_ready),
    .fire       (fire),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .start      (start),
    .reload_now (reload_now),
    .irq        (irq)
  );

  dma_dst_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .burst_mode (burst_mode),
    .beat_size  (beat_size),
    .fixed      (ctrl_q.fixed),
    .start      (start),
    .reload_now (reload_now),
    .init_q     (init_q),
    .sw_wr      (ptr_wr),
    .sw_data    (reg_wdata[ADDR_W-1:0]),
    .ptr_q      (ptr_q)
  );

  assign dst_addr   = ptr_q;
  assign dst_periph = ctrl_q.periph;

  assert_periph_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_CTRL) |=> (dst_periph == $past(reg_wdata[1])));

endmodule

// File: tb/dma_dst_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_dst_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_ack = 1'b0;
  logic        beat_valid = 1'b0;
  logic        beat_ready;
  logic [1:0]  beat_size = 2'd0;
  logic        burst_mode = 1'b0;
  logic [30:0] dst_addr;
  logic        dst_periph;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [30:0] exp_addr, base_addr;

  always #4 clk = ~clk;

  dma_dst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_ack(dma_ack),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_size(beat_size),
    .burst_mode(burst_mode), .dst_addr(dst_addr), .dst_periph(dst_periph), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  function automatic logic [30:0] stepv(input logic [1:0] sz);
    return (sz == 2'd0) ? 31'd1 : (sz == 2'd1) ? 31'd2 : 31'd4;
  endfunction

  // runs n units; last unit expected terminal with given irq value
  task automatic run_units(input int n, input logic [1:0] sz, input bit fx, input bit bm,
                           input bit term_irq, input bit ack_first);
    int nb;
    nb = bm ? 4 : 1;
    for (int u = 0; u < n; u++) begin
      for (int b = 0; b < nb; b++) begin
        bit term;
        term = (u == n - 1) && (b == nb - 1);
        beat_valid = 1'b1; beat_size = sz; burst_mode = bm;
        if (ack_first && u == 0 && b == 0) dma_ack = 1'b1;
        tick();
        dma_ack = 1'b0;
        if (bm) begin
          if (b == 0) base_addr = exp_addr;
          if (b == 3 && fx) exp_addr = base_addr;
          else exp_addr = exp_addr + stepv(sz);
        end else if (!fx) begin
          exp_addr = exp_addr + stepv(sz);
        end
        check(dst_addr == exp_addr, bm ? (fx ? "R6 burst fixed" : "R6 burst inc")
                                       : (fx ? "R5 fixed" : "R4 inc"),
              32'(dst_addr), 32'(exp_addr));
        if (term) begin
          beat_valid = 1'b0;
          check(beat_ready == 1'b0, "R7 ready low after terminal", 32'(beat_ready), 32'd0);
          check(irq == term_irq, "R9 irq at terminal", 32'(irq), 32'(term_irq));
        end else begin
          check(beat_ready == 1'b1 && irq == 1'b0, "R11 mid-run ready, no irq",
                {30'd0, beat_ready, irq}, 32'd2);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(dst_addr == '0 && irq == 1'b0 && beat_ready == 1'b0 && dst_periph == 1'b0,
          "R1 outputs after reset", {28'd0, dst_addr == '0, irq, beat_ready, dst_periph}, 32'h8);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      check(reg_rdata == 32'd0, "R1 register reset", reg_rdata, 32'd0);
    end

    // R2 register map and widths
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    reg_addr = 2'd0; #1;
    check(reg_rdata == 32'h7FFF_FFFF, "R2 start address width", reg_rdata, 32'h7FFF_FFFF);
    reg_addr = 2'd1; #1;
    check(reg_rdata == 32'h0000_000F, "R2 control width", reg_rdata, 32'hF);
    reg_addr = 2'd2; #1;
    check(reg_rdata == 32'h0000_00FF, "R2 count width", reg_rdata, 32'hFF);
    check(dst_periph == 1'b1, "R10 periph set", 32'(dst_periph), 32'd1);
    wr(2'd1, 32'h0000_0000);
    check(dst_periph == 1'b0, "R10 periph clear", 32'(dst_periph), 32'd0);
    wr(2'd3, 32'h0000_1234);
    reg_addr = 2'd3; #1;
    check(reg_rdata == 32'h0000_1234, "R2 pointer write", reg_rdata, 32'h1234);

    // R3 nonzero pointer keeps its value on ack
    wr(2'd0, 32'h0000_1000);
    wr(2'd2, 32'd1);
    wr(2'd3, 32'h0000_0055);
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    check(beat_ready == 1'b1, "R3 start ready", 32'(beat_ready), 32'd1);
    check(dst_addr == 31'h55, "R3 no load on nonzero pointer", 32'(dst_addr), 32'h55);
    exp_addr = 31'h55;
    run_units(1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    tick();
    check(irq == 1'b0, "R7 irq single cycle", 32'(irq), 32'd0);

    // sweep
    for (int c = 0; c < 64; c++) begin
      logic [1:0] sz;
      bit fx, bm, rl, ck;
      int n;
      logic [30:0] init;
      sz = 2'(c & 3); fx = c[2]; bm = c[3]; rl = c[4]; ck = c[5];
      n = 1 + (c % 3);
      init = 31'h0100_0000 + 31'(c) * 31'h1231;
      wr(2'd1, {28'd0, rl, ck, c[0], fx});
      wr(2'd0, 32'(init));
      wr(2'd2, 32'(n));
      wr(2'd3, 32'd0);
      dma_ack = 1'b1; tick(); dma_ack = 1'b0;
      check(dst_addr == init && beat_ready == 1'b1, "R3 start loads address",
            32'(dst_addr), 32'(init));
      exp_addr = init;
      run_units(n, sz, fx, bm, !rl || !ck, 1'b1);
      if (!rl) begin
        beat_valid = 1'b1;
        tick();
        beat_valid = 1'b0;
        check(dst_addr == exp_addr, "R11 beat ignored when stopped", 32'(dst_addr), 32'(exp_addr));
        check(irq == 1'b0 && beat_ready == 1'b0, "R7 stopped, one-cycle irq",
              {30'd0, irq, beat_ready}, 32'd0);
      end else begin
        tick();
        check(dst_addr == init && beat_ready == 1'b1, "R8 reload address and ready",
              32'(dst_addr), 32'(init));
        check(irq == ck, "R9 irq after reload", 32'(irq), 32'(ck));
        wr(2'd1, {28'd0, 1'b0, ck, c[0], fx});
        check(irq == 1'b0, "R9 irq one cycle", 32'(irq), 32'd0);
        exp_addr = init;
        run_units(n, sz, fx, bm, 1'b1, 1'b0);
        tick();
        check(beat_ready == 1'b0, "R8 reloaded count ran out", 32'(beat_ready), 32'd0);
      end
    end

    // R12 start-address write on the terminal edge
    wr(2'd1, 32'h0000_0008);
    wr(2'd0, 32'h0000_2000);
    wr(2'd2, 32'd1);
    wr(2'd3, 32'd0);
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    beat_valid = 1'b1; beat_size = 2'd2; burst_mode = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_3000;
    tick();
    beat_valid = 1'b0; reg_wr = 1'b0;
    check(irq == 1'b1 && beat_ready == 1'b0, "R12 terminal with write", {30'd0, irq, beat_ready}, 32'd2);
    tick();
    check(dst_addr == 31'h3000, "R12 reload takes new address", 32'(dst_addr), 32'h3000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule